// File: doc/BRIEF.md
# Sequence-Selected Multiply/Divide Unit

This block is an unsigned arithmetic coprocessor on an 8-bit register bus. It has six byte-wide operand/result registers and one control register. There is no opcode field. A small tracker watches the order in which software writes the operand registers and infers the operation from that order: a 32-by-16 divide, a 16-by-16 divide or a 16-by-16 multiply. The write that completes a known order starts the computation. After the four value bytes are loaded, a write to the control register starts a 32-bit shift or a normalize.

The arithmetic runs in an iterative engine that handles one bit per clock. `busy` stays high until the results have been written back into the operand registers. The engine then returns to idle. Out-of-order writes and writes made while busy raise a sticky error flag. Reading the control register clears that flag. A zero divisor or a product wider than 16 bits raises an overflow flag.

Tracker states: IDLE, GOT0, GOT01, GOT012, GOT0123, DV32_LO, DV16_LO, MUL_LO, MUL_HI.

Tracker transitions, every one taken on a register write:
- A write to MD0 goes to GOT0 from any state.
- GOT0 goes to GOT01 on an MD1 write and to MUL_LO on an MD4 write.
- GOT01 goes to GOT012 on MD2 and to DV16_LO on MD4.
- GOT012 goes to GOT0123 on MD3.
- GOT0123 goes to DV32_LO on MD4, and launches a shift on a control write, returning to IDLE.
- MUL_LO goes to MUL_HI on MD1.
- MD5 launches a 32/16 divide from DV32_LO, a 16/16 divide from DV16_LO and a multiply from MUL_HI. Each launch returns to IDLE.
- Any other write goes to IDLE with an error. The one exception is a control write in IDLE, which causes no error.

Engine states: IDLE, DIV, MUL, SHL, SHR, NRM, WB.
- IDLE leaves on a launch.
- DIV, MUL, SHL and SHR each count down to WB.
- NRM goes to WB once bit 31 is set or the value is zero.
- WB returns to IDLE.

Top module: `seq_mdu`

## Requirements
- R1: After reset, all seven registers read 00h and `busy` is 0.
- R2: Register addresses:
  - MD0 to MD5 sit at E9h to EEh.
  - The control register sits at EFh. Its bit 7 is the error flag, bit 6 is the overflow flag, bit 5 is the shift direction and bits 4:0 are the shift count.
  - A write to an MD register while idle is stored and reads back.
- R3: The write order MD0, MD1, MD2, MD3, MD4, MD5 starts a 32/16 divide. The dividend is MD3..MD0 and the divisor is MD5:MD4. The quotient lands in MD3..MD0 and the remainder in MD5:MD4. `busy` stays high for 33 cycles.
- R4: The write order MD0, MD1, MD4, MD5 starts a 16/16 divide. The quotient lands in MD1:MD0 and the remainder in MD5:MD4. MD2 and MD3 keep their values. `busy` stays high for 17 cycles.
- R5: The write order MD0, MD4, MD1, MD5 starts a 16x16 multiply of MD1:MD0 by MD5:MD4. The product lands in MD3..MD0. `busy` stays high for 17 cycles.
- R6: The overflow flag behaves as follows:
  - A divide with a zero divisor sets it, does not raise `busy`, and leaves MD0 to MD5 unchanged.
  - A product above FFFFh sets it.
  - Every other launch clears it.
- R7: After MD0 to MD3 are written, a control write with a nonzero count shifts MD3..MD0 by that count. Direction bit 1 shifts right and 0 shifts left. `busy` stays high for count+1 cycles, and the count is kept.
- R8: A control write with count 0 normalizes instead. The value is shifted left until bit 31 is 1, and the count field receives the number of shifts. `busy` stays high for shifts+2 cycles. A zero value stays zero with count 0.
- R9: A write that breaks every known order sets the error flag and starts nothing.
- R10: A write while busy is not stored and sets the error flag. The running operation still completes correctly.
- R11: Reading the control register clears the error flag and leaves the overflow flag as it was.
- R12: A write to MD0 in the middle of an order restarts tracking without an error.
- R13: A control write while no order is pending stores the direction and count, raises no error and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, taken on the rising clock edge |
| rd | input | 1 | Read strobe; a read of the control register clears the error flag |
| rdata | output | 8 | Combinational read data for `addr` |
| busy | output | 1 | High while an operation runs or writes back |

## Verification
The bench aims at the following cases, and for each one says what a wrong design would do:
- A zero divisor: a design that divides anyway would raise `busy` and overwrite the operand registers.
- The multiply order, which interleaves MD4 between MD0 and MD1: a tracker that expects linear order would flag an error.
- The 16/16 divide: a design that writes back a full 32-bit quotient would corrupt MD2 and MD3.
- Normalize of a zero value and of a value already normalized: a loop without an exit test would hang or report a wrong count.
- Writes issued while busy and restarts on MD0: these show whether a design stores data it should refuse and whether it raises false errors.

// File: rtl/seq_mdu_pkg.sv
package seq_mdu_pkg;
    localparam int NUM_MD = 6;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int STEP_W = $clog2(WORD_W) + 1;
    localparam int SC_W   = $clog2(WORD_W);

    typedef enum logic [1:0] {
        OP_D32 = 2'd0,
        OP_D16 = 2'd1,
        OP_MUL = 2'd2,
        OP_SHF = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        T_IDLE, T_GOT0, T_GOT01, T_GOT012, T_GOT0123,
        T_DV32_LO, T_DV16_LO, T_MUL_LO, T_MUL_HI
    } trk_e;

    typedef enum logic [2:0] {
        E_IDLE, E_DIV, E_MUL, E_SHL, E_SHR, E_NRM, E_WB
    } eng_e;
endpackage

// File: rtl/seq_mdu_track.sv
module seq_mdu_track
    import seq_mdu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       md_wr,
    input  logic [2:0] md_idx,
    input  logic       ctl_wr,
    input  logic       busy,
    output logic       launch,
    output op_e        op,
    output logic       seq_err
);
    trk_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= T_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d    = st_q;
        launch  = 1'b0;
        op      = OP_D32;
        seq_err = 1'b0;
        if (busy && (md_wr || ctl_wr)) begin
            seq_err = 1'b1;
            st_d    = T_IDLE;
        end else if (md_wr && md_idx == 3'd0) begin
            st_d = T_GOT0;
        end else if (md_wr || ctl_wr) begin
            seq_err = 1'b1;
            st_d    = T_IDLE;
            unique case (st_q)
                T_IDLE:    if (ctl_wr) seq_err = 1'b0;
                T_GOT0: begin
                    if (md_wr && md_idx == 3'd1) begin st_d = T_GOT01;  seq_err = 1'b0; end
                    if (md_wr && md_idx == 3'd4) begin st_d = T_MUL_LO; seq_err = 1'b0; end
                end
                T_GOT01: begin
                    if (md_wr && md_idx == 3'd2) begin st_d = T_GOT012;  seq_err = 1'b0; end
                    if (md_wr && md_idx == 3'd4) begin st_d = T_DV16_LO; seq_err = 1'b0; end
                end
                T_GOT012:
                    if (md_wr && md_idx == 3'd3) begin st_d = T_GOT0123; seq_err = 1'b0; end
                T_GOT0123: begin
                    if (md_wr && md_idx == 3'd4) begin st_d = T_DV32_LO; seq_err = 1'b0; end
                    if (ctl_wr) begin launch = 1'b1; op = OP_SHF; seq_err = 1'b0; end
                end
                T_DV32_LO:
                    if (md_wr && md_idx == 3'd5) begin launch = 1'b1; op = OP_D32; seq_err = 1'b0; end
                T_DV16_LO:
                    if (md_wr && md_idx == 3'd5) begin launch = 1'b1; op = OP_D16; seq_err = 1'b0; end
                T_MUL_LO:
                    if (md_wr && md_idx == 3'd1) begin st_d = T_MUL_HI; seq_err = 1'b0; end
                T_MUL_HI:
                    if (md_wr && md_idx == 3'd5) begin launch = 1'b1; op = OP_MUL; seq_err = 1'b0; end
                default: st_d = T_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seq_mdu_engine.sv
module seq_mdu_engine
    import seq_mdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_e               op,
    input  logic [WORD_W-1:0] a_in,
    input  logic [HALF_W-1:0] b_in,
    input  logic              sh_dir,
    input  logic [SC_W-1:0]   sh_cnt,
    output logic              busy,
    output logic              wb,
    output logic [WORD_W-1:0] res,
    output logic [HALF_W-1:0] rem,
    output logic [SC_W-1:0]   nrm_cnt,
    output logic              was_nrm
);
    eng_e              st_q, st_d;
    logic [WORD_W-1:0] acc_q;
    logic [HALF_W-1:0] rem_q, mc_q;
    logic [STEP_W-1:0] steps_q;
    logic [SC_W-1:0]   ncnt_q;
    logic              nrm_q;

    // one restoring-divide step
    logic [HALF_W:0]   div_rs;
    logic              div_ge;
    logic [HALF_W-1:0] div_rem;
    assign div_rs  = {rem_q, acc_q[WORD_W-1]};
    assign div_ge  = div_rs >= {1'b0, mc_q};
    assign div_rem = div_ge ? (div_rs[HALF_W-1:0] - mc_q) : div_rs[HALF_W-1:0];

    // one shift-add multiply step
    logic [HALF_W:0] mul_sum;
    assign mul_sum = {1'b0, acc_q[WORD_W-1:HALF_W]} + (acc_q[0] ? {1'b0, mc_q} : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= E_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            E_IDLE: if (start) begin
                unique case (op)
                    OP_D32, OP_D16: st_d = E_DIV;
                    OP_MUL:         st_d = E_MUL;
                    OP_SHF:         st_d = (sh_cnt == '0) ? E_NRM : (sh_dir ? E_SHR : E_SHL);
                endcase
            end
            E_DIV, E_MUL, E_SHL, E_SHR: if (steps_q == STEP_W'(1)) st_d = E_WB;
            E_NRM: if (acc_q[WORD_W-1] || acc_q == '0) st_d = E_WB;
            E_WB:  st_d = E_IDLE;
            default: st_d = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0; rem_q <= '0; mc_q <= '0;
            steps_q <= '0; ncnt_q <= '0; nrm_q <= 1'b0;
        end else begin
            unique case (st_q)
                E_IDLE: if (start) begin
                    rem_q  <= '0;
                    ncnt_q <= '0;
                    nrm_q  <= (op == OP_SHF) && (sh_cnt == '0);
                    unique case (op)
                        OP_D32: begin acc_q <= a_in; mc_q <= b_in; steps_q <= STEP_W'(WORD_W); end
                        OP_D16: begin
                            acc_q   <= {a_in[HALF_W-1:0], {HALF_W{1'b0}}};
                            mc_q    <= b_in;
                            steps_q <= STEP_W'(HALF_W);
                        end
                        OP_MUL: begin
                            acc_q   <= {{HALF_W{1'b0}}, b_in};
                            mc_q    <= a_in[HALF_W-1:0];
                            steps_q <= STEP_W'(HALF_W);
                        end
                        OP_SHF: begin acc_q <= a_in; steps_q <= STEP_W'(sh_cnt); end
                    endcase
                end
                E_DIV: begin
                    rem_q   <= div_rem;
                    acc_q   <= {acc_q[WORD_W-2:0], div_ge};
                    steps_q <= steps_q - 1'b1;
                end
                E_MUL: begin
                    acc_q   <= {mul_sum, acc_q[HALF_W-1:1]};
                    steps_q <= steps_q - 1'b1;
                end
                E_SHL: begin acc_q <= acc_q << 1; steps_q <= steps_q - 1'b1; end
                E_SHR: begin acc_q <= acc_q >> 1; steps_q <= steps_q - 1'b1; end
                E_NRM: if (!(acc_q[WORD_W-1] || acc_q == '0)) begin
                    acc_q  <= acc_q << 1;
                    ncnt_q <= ncnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy    = (st_q != E_IDLE);
    assign wb      = (st_q == E_WB);
    assign res     = acc_q;
    assign rem     = rem_q;
    assign nrm_cnt = ncnt_q;
    assign was_nrm = nrm_q;
endmodule

// File: rtl/seq_mdu.sv
module seq_mdu
    import seq_mdu_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'hE9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       wr,
    input  logic       rd,
    output logic [7:0] rdata,
    output logic       busy
);
    localparam logic [7:0] CTL_OFF = 8'(NUM_MD);

    logic [NUM_MD-1:0][7:0] md_q;
    logic                   err_q, ovf_q, dir_q;
    logic [SC_W-1:0]        sc_q;
    op_e                    op_q;

    logic [7:0]        off;
    logic              in_md, in_ctl, md_wr, ctl_wr;
    logic [2:0]        idx;
    logic              trk_launch, trk_err, zero_div;
    op_e               trk_op;
    logic [HALF_W-1:0] b_in;
    logic              eng_wb, eng_nrm;
    logic [WORD_W-1:0] eng_res;
    logic [HALF_W-1:0] eng_rem;
    logic [SC_W-1:0]   eng_ncnt;

    assign off    = addr - BASE_ADDR;
    assign in_md  = off < CTL_OFF;
    assign in_ctl = off == CTL_OFF;
    assign idx    = off[2:0];
    assign md_wr  = wr && in_md;
    assign ctl_wr = wr && in_ctl;
    assign b_in   = {wdata, md_q[4]};
    assign zero_div = (trk_op == OP_D32 || trk_op == OP_D16) && b_in == '0;

    seq_mdu_track u_trk (
        .clk(clk), .rst_n(rst_n), .md_wr(md_wr), .md_idx(idx), .ctl_wr(ctl_wr),
        .busy(busy), .launch(trk_launch), .op(trk_op), .seq_err(trk_err)
    );

    seq_mdu_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(trk_launch && !zero_div), .op(trk_op),
        .a_in(md_q[3:0]), .b_in(b_in), .sh_dir(wdata[5]), .sh_cnt(wdata[SC_W-1:0]),
        .busy(busy), .wb(eng_wb), .res(eng_res), .rem(eng_rem),
        .nrm_cnt(eng_ncnt), .was_nrm(eng_nrm)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            md_q <= '0; err_q <= 1'b0; ovf_q <= 1'b0;
            dir_q <= 1'b0; sc_q <= '0; op_q <= OP_D32;
        end else begin
            if (!busy && md_wr) md_q[idx] <= wdata;
            if (!busy && ctl_wr) begin
                dir_q <= wdata[5];
                sc_q  <= wdata[SC_W-1:0];
            end
            if (trk_launch) begin
                ovf_q <= zero_div;
                op_q  <= trk_op;
            end
            if (eng_wb) begin
                unique case (op_q)
                    OP_D32: begin md_q[3:0] <= eng_res; md_q[5:4] <= eng_rem; end
                    OP_D16: begin md_q[1:0] <= eng_res[HALF_W-1:0]; md_q[5:4] <= eng_rem; end
                    OP_MUL: begin
                        md_q[3:0] <= eng_res;
                        ovf_q     <= eng_res[WORD_W-1:HALF_W] != '0;
                    end
                    OP_SHF: begin
                        md_q[3:0] <= eng_res;
                        if (eng_nrm) sc_q <= eng_ncnt;
                    end
                endcase
            end
            if (trk_err)                 err_q <= 1'b1;
            else if (rd && in_ctl)       err_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (in_md)  rdata = md_q[idx];
        if (in_ctl) rdata = {err_q, ovf_q, dir_q, sc_q};
    end
endmodule

// File: rtl/seq_mdu_chk.sv
module seq_mdu_chk
    import seq_mdu_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'hE9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [7:0]             addr,
    input logic [7:0]             wdata,
    input logic                   wr,
    input logic                   rd,
    input logic                   busy,
    input logic                   wb,
    input logic                   launch,
    input op_e                    lop,
    input logic                   err,
    input logic                   ovf,
    input logic                   nrm,
    input logic [NUM_MD-1:0][7:0] md
);
    logic zd, hit;
    assign zd  = launch && (lop == OP_D32 || lop == OP_D16) && {wdata, md[4]} == 16'h0;
    assign hit = (addr >= BASE_ADDR) && (addr <= BASE_ADDR + 8'd6);

    p_zero_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
        zd |=> (ovf && !busy));

    p_launch_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !zd) |=> (busy && !ovf));

    p_busy_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr && hit) |=> err);

    p_hold_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wb) |=> $stable(md));

    p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && addr == BASE_ADDR + 8'd6) |=> !err);

    p_norm_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb && nrm) |=> (md[3][7] || md[3:0] == 32'h0));
endmodule

bind seq_mdu seq_mdu_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .busy(busy), .wb(eng_wb), .launch(trk_launch), .lop(trk_op),
    .err(err_q), .ovf(ovf_q), .nrm(eng_nrm), .md(md_q)
);

// File: tb/sim_seq_mdu.sv
module sim_seq_mdu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] rdata;
    logic       busy;
    int total = 0, bad = 0;

    localparam logic [7:0] A0 = 8'hE9, A1 = 8'hEA, A2 = 8'hEB, A3 = 8'hEC,
                           A4 = 8'hED, A5 = 8'hEE, AC = 8'hEF;

    always #2 clk = ~clk;

    seq_mdu u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                .wr(wr), .rd(rd), .rdata(rdata), .busy(busy));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic r32(output logic [31:0] v);
        logic [7:0] b0, b1, b2, b3;
        rreg(A0, b0); rreg(A1, b1); rreg(A2, b2); rreg(A3, b3);
        v = {b3, b2, b1, b0};
    endtask

    task automatic r16hi(output logic [15:0] v);
        logic [7:0] b4, b5;
        rreg(A4, b4); rreg(A5, b5);
        v = {b5, b4};
    endtask

    // reference busy length: counts negedge samples with busy high
    task automatic busy_len(input string req, input int exp);
        int n = 0;
        while (busy && n < 200) begin n++; @(negedge clk); end
        check(req, n, exp);
    endtask

    task automatic load32(input logic [31:0] v);
        wreg(A0, v[7:0]); wreg(A1, v[15:8]); wreg(A2, v[23:16]); wreg(A3, v[31:24]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  b, c;
        logic [31:0] v, q, e;
        logic [15:0] r, rq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", busy, 0);
        for (int i = 0; i < 7; i++) begin
            rreg(A0 + 8'(i), b);
            check("R1 reg", b, 0);
        end

        // R2 store and readback, control register empty
        wreg(A0, 8'hA5);
        rreg(A0, b); check("R2 md0 readback", b, 8'hA5);
        rreg(AC, b); check("R2 ctl", b, 8'h00);

        // R3 32/16 divide
        load32(32'h1234_5678); wreg(A4, 8'h34); wreg(A5, 8'h12);
        busy_len("R3 busy", 33);
        r32(q); r16hi(r);
        check("R3 quotient", q, 32'h1234_5678 / 32'h1234);
        check("R3 remainder", r, 16'(32'h1234_5678 % 32'h1234));
        rreg(AC, b); check("R3 flags", b[7:6], 0);

        // R4 16/16 divide; MD2/MD3 keep prior quotient bytes
        e = q;
        wreg(A0, 8'hEF); wreg(A1, 8'hBE); wreg(A4, 8'h11); wreg(A5, 8'h00);
        busy_len("R4 busy", 17);
        r32(v); r16hi(r);
        check("R4 quotient", v[15:0], 16'hBEEF / 16'h0011);
        check("R4 md3md2 kept", v[31:16], e[31:16]);
        check("R4 remainder", r, 16'hBEEF % 16'h0011);

        // R5 multiply, no overflow
        wreg(A0, 8'hFF); wreg(A4, 8'h01); wreg(A1, 8'h00); wreg(A5, 8'h01);
        busy_len("R5 busy", 17);
        r32(v); check("R5 product", v, 32'h00FF * 32'h0101);
        rreg(AC, b); check("R6 ovf clear small product", b[6], 0);

        // R5/R6 multiply with product above FFFFh
        wreg(A0, 8'h34); wreg(A4, 8'h78); wreg(A1, 8'h12); wreg(A5, 8'h56);
        busy_len("R5 busy big", 17);
        r32(v); check("R5 product big", v, 32'h1234 * 32'h5678);
        rreg(AC, b); check("R6 ovf set", b[6], 1);

        // R6 zero divisor
        wreg(A0, 8'h21); wreg(A1, 8'h43); wreg(A4, 8'h00); wreg(A5, 8'h00);
        check("R6 zero div no busy", busy, 0);
        r32(v); r16hi(r);
        check("R6 md0md1 unchanged", v[15:0], 16'h4321);
        check("R6 divisor regs", r, 0);
        rreg(AC, b); check("R6 ovf zero div", b[6], 1);
        rreg(AC, b); check("R11 ovf kept after read", b[6], 1);

        // R6 next launch clears overflow
        wreg(A0, 8'h03); wreg(A4, 8'h05); wreg(A1, 8'h00); wreg(A5, 8'h00);
        busy_len("R5 busy small", 17);
        rreg(AC, b); check("R6 ovf cleared by launch", b[6], 0);

        // R7 shift left by 4
        load32(32'h0000_00F1); wreg(AC, 8'h04);
        busy_len("R7 busy left", 5);
        r32(v); check("R7 shift left", v, 32'h0000_0F10);
        rreg(AC, b); check("R7 ctl kept", b[5:0], 6'h04);

        // R7 shift right by 31
        load32(32'h8000_0001); wreg(AC, 8'h3F);
        busy_len("R7 busy right", 32);
        r32(v); check("R7 shift right", v, 32'h1);

        // R8 normalize
        begin
            int n = 0;
            e = 32'h0001_2345;
            while (e != 0 && !e[31]) begin e = e << 1; n++; end
            load32(32'h0001_2345); wreg(AC, 8'h00);
            busy_len("R8 busy", n + 2);
            r32(v); check("R8 normalized", v, e);
            rreg(AC, b); check("R8 count", b[4:0], n);
        end
        load32(32'h0); wreg(AC, 8'h00);
        busy_len("R8 busy zero", 2);
        r32(v); check("R8 zero value", v, 0);
        rreg(AC, b); check("R8 zero count", b[4:0], 0);
        load32(32'h8000_0000); wreg(AC, 8'h00);
        busy_len("R8 busy already", 2);
        r32(v); check("R8 already normalized", v, 32'h8000_0000);

        // R9 broken order, R11 read clears error
        wreg(A0, 8'h10); wreg(A2, 8'h20);
        check("R9 no launch", busy, 0);
        rreg(AC, b); check("R9 err set", b[7], 1);
        rreg(AC, b); check("R11 err cleared", b[7], 0);

        // R12 restart on MD0 then multiply
        wreg(A0, 8'h99); wreg(A1, 8'h99); wreg(A0, 8'h07); wreg(A4, 8'h09);
        wreg(A1, 8'h00); wreg(A5, 8'h00);
        busy_len("R12 busy", 17);
        r32(v); check("R12 product", v, 32'd63);
        rreg(AC, b); check("R12 no err", b[7], 0);

        // R10 write while busy
        load32(32'h0000_1000); wreg(A4, 8'h10); wreg(A5, 8'h00);
        check("R10 busy", busy, 1);
        wreg(A0, 8'hFF);
        while (busy) @(negedge clk);
        r32(v); r16hi(r);
        check("R10 quotient intact", v, 32'h100);
        check("R10 remainder", r, 0);
        rreg(AC, b); check("R10 err", b[7], 1);

        // R13 control write with nothing pending
        rreg(A0, c);
        wreg(AC, 8'h25);
        check("R13 no start", busy, 0);
        rreg(AC, b); check("R13 ctl", b, 8'h25);
        rreg(A0, b); check("R13 md0 unchanged", b, c);

        rq = 0;
        check("R2 end idle", busy, rq[0]);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule